// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog built around a 7-bit down-counter that must be refreshed inside a time window. Bus-clock cycles go first through a fixed base divider, then through a power-of-two prescaler. Each counter tick moves the counter down by one. Software arms the watchdog and refreshes it by writing the control register. A refresh that arrives while the counter is still above the programmed window value is a violation and raises a reset request. If the counter is allowed to drop from 0x40 to 0x3F, that also raises a reset request.

When the counter reaches 0x40, an early-warning flag is set. This gives software one last tick to refresh. The flag drives an interrupt line when its enable bit is set. A debug input pair can freeze the counter while the processor is halted. Once the watchdog is armed it stays armed until the block's own reset.

Top module: `window_wdog`

## Requirements
- R1: After reset the counter reads 0x7F, the watchdog is disarmed, the window is 0x7F, the prescaler select is 0, the interrupt enable and the warning flag are 0, and `rst_req` and `irq` are low.
- R2: The divider produces one counter tick every BASE_DIV × 2^psel bus cycles. It fires when its cycle count is at or above that limit minus one, and a configuration write does not restart it. Between ticks, and when there is no control write, the counter holds its value.
- R3: A control write (address 0) loads the counter from data bits [6:0] and arms the watchdog when data bit 7 is 1. This load takes priority over a tick that occurs in the same cycle.
- R4: Once armed, the watchdog stays armed. A control write with bit 7 = 0 does not disarm it.
- R5: While the watchdog is armed, a tick that takes the counter from 0x40 to 0x3F raises `rst_req` for exactly the following cycle. While it is disarmed, this transition raises no request.
- R6: A control write while armed and with the counter above the window value raises `rst_req` in the next cycle. The counter is loaded anyway.
- R7: With the window at 0x7F, no refresh counts as early.
- R8: A tick that takes the counter from 0x41 to 0x40 sets the warning flag (status, address 2, bit 0). A status write with bit 0 = 0 clears the flag. A status write with bit 0 = 1 has no effect. If setting and clearing happen in the same cycle, the set wins.
- R9: `irq` is high exactly while the warning flag and the interrupt enable (configuration bit 9) are both 1.
- R10: While `dbg_halt` and `dbg_freeze_en` are both high, the divider and the counter stop. With `dbg_freeze_en` low, they keep running during a halt.
- R11: Reads are combinational. Address 0 returns {armed, counter} in bits [7:0]. Address 1 returns the window in [6:0], the prescaler select in [8:7] and the interrupt enable in [9]. Address 2 returns the flag in bit 0. Address 3 returns 0, and writes to it do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| dbg_halt | input | 1 | Processor halted in debug |
| dbg_freeze_en | input | 1 | Freeze the counter during a debug halt |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Early-warning interrupt |

## Verification
The properties assume that all inputs are synchronous to `clk`. They also assume that a write is a single-cycle strobe with known address and data. The stretch rules are built on this: a counter holds between ticks unless a control write lands, and a frozen counter changes only through a write. The bench changes every input on the falling edge and never leaves a bus field unknown while `bus_sel` is high. A small base divider keeps the full 0x7F-to-0x3F sweep short. Along the way it visits the early-refresh, late-expiry, sticky-arm and freeze corners.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W  = 7;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_CFG  = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } wdog_reg_e;

  localparam logic [CNT_W-1:0] CNT_INIT  = 7'h7F;
  localparam logic [CNT_W-1:0] WIN_INIT  = 7'h7F;
  localparam logic [CNT_W-1:0] WARN_PRE  = 7'h41;
  localparam logic [CNT_W-1:0] LAST_SAFE = 7'h40;
endpackage

// File: rtl/wdog_divider.sv
module wdog_divider #(
  parameter int BASE_DIV = 4096,
  parameter int PSC_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psel,
  output logic             tick
);
  localparam int MAX_DIV = BASE_DIV << ((1 << PSC_W) - 1);
  localparam int DW      = $clog2(MAX_DIV) + 1;

  logic [DW-1:0] dcnt_q, dcnt_d, limit;

  always_comb begin
    limit  = DW'(BASE_DIV) << psel;
    tick   = run && (dcnt_q >= limit - DW'(1));
    dcnt_d = tick ? '0 : dcnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dcnt_q <= '0;
    else if (run) dcnt_q <= dcnt_d;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_arm,
  input  logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] cnt,
  output logic             armed,
  output logic             rst_req,
  output logic             warn_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             arm_q, arm_d, req_q, req_d;
  logic             cnt_upd, too_soon, expire;

  always_comb begin
    too_soon = load && arm_q && (cnt_q > win);
    expire   = !load && tick && arm_q && (cnt_q == LAST_SAFE);
    warn_evt = !load && tick && (cnt_q == WARN_PRE);
    cnt_upd  = load || tick;
    cnt_d    = load ? load_val : cnt_q - 1'b1;
    arm_d    = arm_q || (load && load_arm);
    req_d    = too_soon || expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
      arm_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (cnt_upd) cnt_q <= cnt_d;
      arm_q <= arm_d;
      req_q <= req_d;
    end
  end

  assign cnt     = cnt_q;
  assign armed   = arm_q;
  assign rst_req = req_q;
endmodule

// File: rtl/window_wdog.sv
module window_wdog
  import wdog_pkg::*;
#(
  parameter int BASE_DIV = 4096,
  parameter int PSC_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt,
  input  logic              dbg_freeze_en,
  output logic              rst_req,
  output logic              irq
);
  localparam int PSC_LSB = CNT_W;
  localparam int IEN_BIT = CNT_W + PSC_W;

  logic             wr_ctrl, wr_cfg, wr_stat;
  logic             halt_freeze, run, div_tick, warn_evt, wd_en;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] win_q, win_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic             ien_q, ien_d, flag_q, flag_d;

  always_comb begin
    wr_ctrl     = bus_sel && bus_wr && (bus_addr == REG_CTRL);
    wr_cfg      = bus_sel && bus_wr && (bus_addr == REG_CFG);
    wr_stat     = bus_sel && bus_wr && (bus_addr == REG_STAT);
    halt_freeze = dbg_halt && dbg_freeze_en;
    run         = !halt_freeze;
  end

  wdog_divider #(.BASE_DIV(BASE_DIV), .PSC_W(PSC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .psel(psc_q), .tick(div_tick)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(div_tick), .load(wr_ctrl),
    .load_val(bus_wdata[CNT_W-1:0]), .load_arm(bus_wdata[CNT_W]),
    .win(win_q), .cnt(cnt_val), .armed(wd_en), .rst_req(rst_req),
    .warn_evt(warn_evt)
  );

  always_comb begin
    win_d  = bus_wdata[CNT_W-1:0];
    psc_d  = bus_wdata[PSC_LSB +: PSC_W];
    ien_d  = bus_wdata[IEN_BIT];
    flag_d = flag_q;
    if (warn_evt)                     flag_d = 1'b1;
    else if (wr_stat && !bus_wdata[0]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= WIN_INIT;
      psc_q  <= '0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_cfg) begin
        win_q <= win_d;
        psc_q <= psc_d;
        ien_q <= ien_d;
      end
      flag_q <= flag_d;
    end
  end

  assign irq = flag_q && ien_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL: bus_rdata[CNT_W:0] = {wd_en, cnt_val};
      REG_CFG:  bus_rdata[IEN_BIT:0] = {ien_q, psc_q, win_q};
      REG_STAT: bus_rdata[0] = flag_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_ctrl,
  input logic       frozen,
  input logic       en,
  input logic [6:0] cnt,
  input logic       flag,
  input logic       rst_req
);
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en); // R4
  AST_REQ_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> en); // R5
  AST_EXPIRE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && !wr_ctrl && cnt == 7'h40) |=> rst_req); // R5
  AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick)); // R8
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !wr_ctrl) |=> $stable(cnt)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_ctrl) |=> $stable(cnt)); // R2
endmodule

bind window_wdog wdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(div_tick), .wr_ctrl(wr_ctrl),
  .frozen(halt_freeze), .en(wd_en), .cnt(cnt_val), .flag(flag_q),
  .rst_req(rst_req)
);

// File: tb/sim_window_wdog.sv
`timescale 1ns/1ps
module sim_window_wdog;
  localparam int BASE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        dbg_halt = 1'b0, dbg_freeze_en = 1'b0;
  logic        rst_req, irq;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string cur = "R1";

  window_wdog #(.BASE_DIV(BASE), .PSC_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_halt(dbg_halt), .dbg_freeze_en(dbg_freeze_en),
    .rst_req(rst_req), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // behavioural reference state
  int m_cnt = 127, m_win = 127, m_psc = 0, m_dv = 0;
  bit m_en = 0, m_ien = 0, m_flag = 0, m_req = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 127; m_win = 127; m_psc = 0; m_dv = 0;
      m_en = 0; m_ien = 0; m_flag = 0; m_req = 0;
    end else begin
      bit tk, wc, wf, ws, req, fset;
      int ncnt;
      tk = 0;
      if (!(dbg_halt && dbg_freeze_en)) begin
        if (m_dv >= (BASE << m_psc) - 1) begin tk = 1; m_dv = 0; end
        else m_dv = m_dv + 1;
      end
      wc = bus_sel && bus_wr && bus_addr == 2'd0;
      wf = bus_sel && bus_wr && bus_addr == 2'd1;
      ws = bus_sel && bus_wr && bus_addr == 2'd2;
      req = 0; fset = 0; ncnt = m_cnt;
      if (wc) begin
        if (m_en && m_cnt > m_win) req = 1;
        ncnt = int'(bus_wdata[6:0]);
        if (bus_wdata[7]) m_en = 1;
      end else if (tk) begin
        if (m_en && m_cnt == 64) req = 1;
        if (m_cnt == 65) fset = 1;
        ncnt = (m_cnt + 127) % 128;
      end
      m_cnt = ncnt;
      if (fset) m_flag = 1;
      else if (ws && !bus_wdata[0]) m_flag = 0;
      if (wf) begin
        m_win = int'(bus_wdata[6:0]);
        m_psc = int'(bus_wdata[8:7]);
        m_ien = bus_wdata[9];
      end
      m_req = req;
    end
  end

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    logic [15:0] v = 16'h0;
    case (a)
      2'd0: v[7:0] = {m_en, 7'(m_cnt)};
      2'd1: v[9:0] = {m_ien, 2'(m_psc), 7'(m_win)};
      2'd2: v[0]   = m_flag;
      default: v = 16'h0;
    endcase
    return v;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h at cycle %0d", cur, what, act, exp, cyc);
    end
  endtask

  // compare every cycle, after the edge has settled and before the next drive
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      #2;
      chk("rst_req", int'(rst_req), int'(m_req));
      chk("irq", int'(irq), int'(m_flag && m_ien));
      chk("rdata", int'(bus_rdata), int'(exp_rd(bus_addr)));
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
    finish_run();
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_addr = 2'(i % 4);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset defaults through every read address
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a);
      #1;
      chk("R1 reset read", int'(bus_rdata), (a == 0) ? 16'h007F : (a == 1) ? 16'h007F : 0);
      @(negedge clk);
    end
    cur = "R2";  idle(60);
    cur = "R8";  idle(300);                 // disarmed sweep past 0x40: flag, no request
    cur = "R9";  wr(2'd1, 16'h027F); idle(5);
    cur = "R8";  wr(2'd2, 16'h0001); idle(3);
                 wr(2'd2, 16'h0000); idle(3);
    cur = "R3";  wr(2'd0, 16'h00FF); idle(10);
    cur = "R7";  wr(2'd0, 16'h00FF); idle(5);
    cur = "R5";  idle(300);                 // armed expiry 0x40 -> 0x3F
    cur = "R4";  wr(2'd0, 16'h0060); idle(5);
    cur = "R6";  wr(2'd1, 16'h0050);
                 wr(2'd0, 16'h00FF); idle(200);
                 wr(2'd0, 16'h00C5); idle(10);
    cur = "R2";  wr(2'd1, 16'h01FF); idle(400);
    cur = "R10"; dbg_halt = 1'b1; dbg_freeze_en = 1'b1; idle(100);
                 dbg_freeze_en = 1'b0; idle(100);
                 dbg_halt = 1'b0; idle(20);
    cur = "R11"; wr(2'd3, 16'hFFFF); idle(8);
    finish_run();
  end
endmodule